// File: doc/BRIEF.md
# Paced Iterative Squaring Node

This block squares an unsigned operand over several clock cycles. It sits in a pipeline that is clocked every cycle. The upstream side offers data with a valid flag, and the node answers with a ready flag. An operand is taken only on a clock edge where both flags are high. The square appears a fixed `LAT` cycles later, marked by an output valid flag. The downstream side returns its own ready flag, so the node can hold a finished result for as long as it is needed.

Two rules decide when the next operand can be taken:
- At least `TII` edges must pass between two accepted operands.
- A result that is still waiting for the downstream side keeps the upstream ready flag low.

The node does not stall a source that offers data too early. Such an offer is simply lost, and a drop counter records it. The upstream side therefore works under a drop policy. The downstream side works under standard valid/ready back-pressure, with one result of storage.

The parameters must satisfy `LAT >= W` and `TII > LAT`. With these values only one operand is ever in flight.

Top module: `paced_square_node`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0, `in_ready` is 1 and `drop_count` is 0.
- R2: An operand is accepted on a rising edge exactly when `in_valid` and `in_ready` are both 1 at that edge. When the valid flag is held high continuously, acceptances occur every `TII` edges.
- R3: The result presented with `out_valid` equals the accepted `in_data` multiplied by itself, as an unsigned `2*W`-bit value.
- R4: `out_valid` becomes 1 directly after the `LAT`-th rising edge that follows the acceptance edge. It is 0 before that point.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change. On an edge where both are 1, the result is delivered and `out_valid` returns to 0.
- R6: After an acceptance edge, `in_ready` is 0 until directly after the `(TII-1)`-th following edge. The next acceptance therefore happens no sooner than `TII` edges after the previous one.
- R7: `in_ready` is 0 whenever `out_valid` is 1.
- R8: An edge with `in_valid` 1 and `in_ready` 0 discards the offered data, which has no effect on any result, and adds one to `drop_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream offers `in_data` |
| in_ready | output | 1 | Node will take an offer on this edge |
| in_data | input | W | Unsigned operand |
| out_valid | output | 1 | `out_data` holds a finished square |
| out_ready | input | 1 | Downstream takes the result on this edge |
| out_data | output | 2*W | Square of the accepted operand |
| drop_count | output | CW | Number of discarded offers, wraps |

## Verification
Every one of the 64 operands of the default 6-bit configuration is sent as a single isolated offer. Each of these runs checks the full latency and interval timeline cycle by cycle, which separates a wrong square from an off-by-one in either counter.

Several further stimulus patterns each target a different failure:
- An offer held high through the whole closed window, carrying different data, shows whether a discarded operand leaks into the result and whether every discarded cycle is counted.
- A valid flag held high for three intervals, with data that changes every cycle, shows whether acceptance lands exactly every `TII` edges and whether each result belongs to the right operand.
- Holding `out_ready` low well past both windows tells true result holding and upstream blocking apart from a node that simply reopens on its timer.

// File: rtl/psn_pkg.sv
package psn_pkg;
  // Width of a counter that must hold values 0..n
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/psn_ii_timer.sv
module psn_ii_timer #(
  parameter int TII = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle
);
  localparam int CW = psn_pkg::cnt_bits(TII);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= CW'(TII - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);

  AST_TIMER_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle) else $error("restart while pacing window open"); // R6
endmodule

// File: rtl/psn_sqr_iter.sv
module psn_sqr_iter #(
  parameter int W   = 6,
  parameter int LAT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] din,
  output logic         done,
  output logic [2*W-1:0] prod
);
  localparam int LW = psn_pkg::cnt_bits(LAT);
  localparam int PW = 2 * W;

  logic [LW-1:0] lat_q;
  logic [PW-1:0] acc_q, mcand_q;
  logic [W-1:0]  mplier_q;
  logic [PW-1:0] acc_step;

  // one shift-add step per busy cycle; extra cycles add zero
  assign acc_step = acc_q + (mplier_q[0] ? mcand_q : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q    <= '0;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (start) begin
      lat_q    <= LW'(LAT);
      acc_q    <= '0;
      mcand_q  <= PW'(din);
      mplier_q <= din;
    end else if (lat_q != '0) begin
      lat_q    <= lat_q - 1'b1;
      acc_q    <= acc_step;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end

  assign done = (lat_q == LW'(1));
  assign prod = acc_step;

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (lat_q == '0) || done) else $error("operand taken mid-computation"); // R6
endmodule

// File: rtl/psn_out_reg.sv
module psn_out_reg #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid) else $error("held result overwritten"); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("result not held"); // R5
endmodule

// File: rtl/psn_drop_ctr.sv
module psn_drop_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (count == $past(count) + 1'b1)) else $error("drop not counted"); // R8
endmodule

// File: rtl/paced_square_node.sv
module paced_square_node #(
  parameter int W   = 6,
  parameter int LAT = 8,
  parameter int TII = 10,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_data,
  output logic [CW-1:0]  drop_count
);
  localparam int DW  = 2 * W;
  localparam int SAT = TII + LAT;
  localparam int SW  = psn_pkg::cnt_bits(SAT);

  logic take, drop, ii_idle, calc_done;
  logic [DW-1:0] calc_prod;

  assign in_ready = ii_idle && !out_valid;
  assign take     = in_valid && in_ready;
  assign drop     = in_valid && !in_ready;

  psn_ii_timer #(.TII(TII)) u_pace (
    .clk(clk), .rst_n(rst_n), .start(take), .idle(ii_idle)
  );

  psn_sqr_iter #(.W(W), .LAT(LAT)) u_calc (
    .clk(clk), .rst_n(rst_n), .start(take), .din(in_data),
    .done(calc_done), .prod(calc_prod)
  );

  psn_out_reg #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(calc_done), .din(calc_prod),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  psn_drop_ctr #(.CW(CW)) u_drops (
    .clk(clk), .rst_n(rst_n), .inc(drop), .count(drop_count)
  );

  // independent edge counter since last acceptance, for timing checks
  logic [SW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_q <= SW'(SAT);
    else if (take)                 since_q <= '0;
    else if (since_q != SW'(SAT))  since_q <= since_q + 1'b1;
  end

  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (since_q >= SW'(TII - 1))) else $error("accept interval too short"); // R6
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (since_q == SW'(LAT))) else $error("latency mismatch"); // R4
  AST_BLOCK_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready) else $error("ready while result held"); // R7
endmodule

// File: tb/paced_square_node_tb.sv
module paced_square_node_tb;
  localparam int W   = 6;
  localparam int LAT = 8;
  localparam int TII = 10;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [2*W-1:0] out_data;
  logic [CW-1:0] drop_count;

  int nchk = 0;
  int nfail = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  paced_square_node #(.W(W), .LAT(LAT), .TII(TII), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .drop_count(drop_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pat(input int c);
    return (c * 5 + 3) % 64;
  endfunction

  // isolated offer; optional extra offer held through the closed window
  task automatic run_one(input int x, input bit extra, input int xd);
    int d0;
    while (!in_ready) @(negedge clk);
    d0 = int'(drop_count);
    in_valid = 1'b1;
    in_data  = W'(x);
    @(negedge clk);
    if (extra) in_data = W'(xd);
    else       in_valid = 1'b0;
    chk("R6", "in_ready after accept", int'(in_ready), 0);
    for (int j = 1; j <= TII - 1; j++) begin
      @(negedge clk);
      chk("R4", "out_valid timeline", int'(out_valid), (j == LAT) ? 1 : 0);
      chk("R6", "in_ready timeline", int'(in_ready), (j >= TII - 1) ? 1 : 0);
      if (j == LAT) chk("R3", "square value", int'(out_data), x * x);
      if (j == TII - 1) in_valid = 1'b0;
    end
    if (extra) chk("R8", "drops counted", int'(drop_count) - d0, TII - 1);
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
    chk("R1", "drop_count after reset", int'(drop_count), 0);

    // exhaustive isolated operands (R2 R3 R4 R6)
    for (int x = 0; x < 64; x++) run_one(x, 1'b0, 0);

    // early offers with other data are discarded (R8)
    for (int x = 1; x < 64; x += 9) run_one(x, 1'b1, 63 - x);

    // continuous valid: accepts every TII edges (R2)
    while (!in_ready) @(negedge clk);
    d0 = int'(drop_count);
    in_valid = 1'b1;
    for (int c = 0; c < 3 * TII; c++) begin
      in_data = W'(pat(c));
      @(negedge clk);
      if (c >= LAT && (c - LAT) % TII == 0) begin
        chk("R2", "paced out_valid", int'(out_valid), 1);
        chk("R2", "paced result", int'(out_data), pat(c - LAT) * pat(c - LAT));
      end else begin
        chk("R2", "paced out_valid idle", int'(out_valid), 0);
      end
    end
    in_valid = 1'b0;
    chk("R8", "paced drops", int'(drop_count) - d0, 3 * TII - 3);

    // back-pressure: result held, upstream blocked (R5 R7)
    while (!in_ready) @(negedge clk);
    out_ready = 1'b0;
    d0 = int'(drop_count);
    in_valid = 1'b1;
    in_data = W'(45);
    @(negedge clk);
    in_data = W'(7);
    for (int j = 1; j <= LAT + 20; j++) begin
      @(negedge clk);
      chk("R5", "held out_valid", int'(out_valid), (j >= LAT) ? 1 : 0);
      chk("R7", "in_ready while held", int'(in_ready), 0);
      if (j >= LAT) chk("R5", "held data", int'(out_data), 45 * 45);
    end
    in_valid = 1'b0;
    chk("R8", "drops while held", int'(drop_count) - d0, LAT + 20);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R5", "out_valid after delivery", int'(out_valid), 0);
    chk("R7", "in_ready after delivery", int'(in_ready), 1);

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule